// File: doc/BRIEF.md
# Scalar Float Compare Flag Unit

This unit compares two IEEE-754 binary floating-point scalars and reports the result as processor-style condition flags. It decides between four outcomes: unordered, greater, less and equal. Each outcome maps to a fixed pattern on the zero, parity and carry flags. The overflow, sign and auxiliary-carry flags are always cleared.

The unit takes a compare variant select and an invalid-exception mask. In the quiet variant, only a signaling NaN raises the invalid-operation indication. In the signaling (ordered) variant, any NaN raises it. When that exception is raised and not masked, the flag write is suppressed and the flags keep their previous values.

The format is set by the exponent and mantissa width parameters; the defaults give single precision. The result is registered and appears one clock after the input strobe.

Top module: `fcmp_flags`

## Requirements
- R1: If either operand is a NaN, the result is unordered and a flag write gives ZF=1, PF=1, CF=1. An operand is a NaN when its exponent field is all ones and its mantissa field is nonzero. It is signaling when the top mantissa bit is 0 and quiet when that bit is 1.
- R2: If operand A is greater than operand B, a flag write gives ZF=0, PF=0, CF=0.
- R3: If operand A is less than operand B, a flag write gives ZF=0, PF=0, CF=1. Ordering follows true value, and denormals are ordered by their magnitude.
- R4: If the operands are equal, a flag write gives ZF=1, PF=0, CF=0. Positive zero and negative zero count as equal.
- R5: OF, SF and AF always read 0.
- R6: With `ordered_mode`=0, `invalid` is raised only when an operand is a signaling NaN.
- R7: With `ordered_mode`=1, `invalid` is raised when an operand is any NaN.
- R8: When `invalid` is raised with `inv_mask`=0, `flag_we` is 0 and ZF, PF and CF keep their previous values. With `inv_mask`=1 the flags are written normally.
- R9: `out_valid`, `flag_we`, `invalid` and the new flags appear exactly one clock after `in_valid`. Without `in_valid`, `flag_we` and `invalid` are 0 and the flags hold.
- R10: A synchronous active-high reset clears all flags, `flag_we`, `invalid` and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands present this cycle |
| op_a | input | 1+EXP_W+MAN_W | Operand A |
| op_b | input | 1+EXP_W+MAN_W | Operand B |
| ordered_mode | input | 1 | 1: any NaN raises invalid; 0: only a signaling NaN does |
| inv_mask | input | 1 | 1: invalid exception masked |
| out_valid | output | 1 | Result present |
| zf | output | 1 | Zero flag |
| pf | output | 1 | Parity flag |
| cf | output | 1 | Carry flag |
| of | output | 1 | Overflow flag, always 0 |
| sf | output | 1 | Sign flag, always 0 |
| af | output | 1 | Auxiliary-carry flag, always 0 |
| flag_we | output | 1 | Flags were written this cycle |
| invalid | output | 1 | Invalid-operation raised |

## Verification
The bench builds the unit with EXP_W=3 and MAN_W=2, a six-bit format. In that format every ordered pair of encodings can be applied under all four combinations of variant and mask. The sweep therefore covers every class pairing: both zeros, denormals, normals, both infinities, and quiet and signaling NaNs on either side. Idle cycles are inserted among the vectors to show that the flags hold without a strobe. Suppressed writes are followed by unsuppressed ones, so the kept values are observed and then replaced.

// File: rtl/fcmp_flags.sv
module fcmp_flags #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [EXP_W+MAN_W:0]     op_a,
  input  logic [EXP_W+MAN_W:0]     op_b,
  input  logic                     ordered_mode,
  input  logic                     inv_mask,
  output logic                     out_valid,
  output logic                     zf,
  output logic                     pf,
  output logic                     cf,
  output logic                     of,
  output logic                     sf,
  output logic                     af,
  output logic                     flag_we,
  output logic                     invalid
);
  localparam int W = 1 + EXP_W + MAN_W;

  wire nan_a  = (&op_a[W-2:MAN_W]) & (|op_a[MAN_W-1:0]);
  wire nan_b  = (&op_b[W-2:MAN_W]) & (|op_b[MAN_W-1:0]);
  wire snan_a = nan_a & ~op_a[MAN_W-1];
  wire snan_b = nan_b & ~op_b[MAN_W-1];
  wire both_zero = ~|{op_a[W-2:0], op_b[W-2:0]};

  wire [W-1:0] key_a = op_a[W-1] ? ~op_a : (op_a ^ {1'b1, {(W-1){1'b0}}});
  wire [W-1:0] key_b = op_b[W-1] ? ~op_b : (op_b ^ {1'b1, {(W-1){1'b0}}});

  wire unord = nan_a | nan_b;
  wire equal = both_zero | (key_a == key_b);
  wire less  = ~equal & (key_a < key_b);
  wire raise = ordered_mode ? unord : (snan_a | snan_b);
  wire write = in_valid & ~(raise & ~inv_mask);

  logic [2:0] pattern;
  always_comb begin
    if (unord)      pattern = 3'b111;
    else if (equal) pattern = 3'b100;
    else if (less)  pattern = 3'b001;
    else            pattern = 3'b000;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      flag_we   <= 1'b0;
      invalid   <= 1'b0;
      {zf, pf, cf} <= 3'b000;
      {of, sf, af} <= 3'b000;
    end else begin
      out_valid <= in_valid;
      flag_we   <= write;
      invalid   <= in_valid & raise;
      if (write) begin
        {zf, pf, cf} <= pattern;
        {of, sf, af} <= 3'b000;
      end
    end
  end
endmodule

// File: rtl/fcmp_flags_chk.sv
module fcmp_flags_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic inv_mask,
  input logic out_valid,
  input logic zf,
  input logic pf,
  input logic cf,
  input logic of,
  input logic sf,
  input logic af,
  input logic flag_we,
  input logic invalid
);
  a_r5_zero_flags: assert property (@(posedge clk) disable iff (rst)
    !(of | sf | af));

  a_r1_pattern: assert property (@(posedge clk) disable iff (rst)
    flag_we |-> (!pf || (zf && cf)));

  a_r9_latency_on: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r9_latency_off: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && !flag_we && !invalid);

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !flag_we |-> $stable({zf, pf, cf}));

  a_r8_suppress: assert property (@(posedge clk) disable iff (rst)
    in_valid && !inv_mask |=> !(invalid && flag_we));

  a_r8_masked: assert property (@(posedge clk) disable iff (rst)
    in_valid && inv_mask |=> flag_we);
endmodule

bind fcmp_flags fcmp_flags_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .inv_mask(inv_mask),
  .out_valid(out_valid), .zf(zf), .pf(pf), .cf(cf), .of(of), .sf(sf),
  .af(af), .flag_we(flag_we), .invalid(invalid)
);

// File: tb/fcmp_flags_tb_top.sv
`timescale 1ns/1ps
module fcmp_flags_tb_top;
  localparam int EW = 3;
  localparam int MW = 2;
  localparam int W  = 1 + EW + MW;
  localparam int BIAS = (1 << (EW - 1)) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic ordered_mode = 1'b0, inv_mask = 1'b0;
  logic out_valid, zf, pf, cf, of, sf, af, flag_we, invalid;

  always #2 clk = ~clk;

  fcmp_flags #(.EXP_W(EW), .MAN_W(MW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .ordered_mode(ordered_mode), .inv_mask(inv_mask), .out_valid(out_valid),
    .zf(zf), .pf(pf), .cf(cf), .of(of), .sf(sf), .af(af),
    .flag_we(flag_we), .invalid(invalid)
  );

  int vectors = 0, miscompares = 0;
  bit done = 0;

  logic [2:0] e_flags = 3'b000;
  logic e_valid = 0, e_we = 0, e_inv = 0;
  string e_tag = "R10";

  function automatic bit is_nan(logic [W-1:0] x);
    return (x[W-2:MW] == {EW{1'b1}}) && (x[MW-1:0] != 0);
  endfunction

  function automatic bit is_snan(logic [W-1:0] x);
    return is_nan(x) && !x[MW-1];
  endfunction

  function automatic real value(logic [W-1:0] x);
    int e = int'(x[W-2:MW]);
    int m = int'(x[MW-1:0]);
    real v;
    if (e == (1 << EW) - 1) v = 1.0e30;
    else if (e == 0) v = (real'(m) / real'(1 << MW)) * (2.0 ** (1 - BIAS));
    else v = (1.0 + real'(m) / real'(1 << MW)) * (2.0 ** (e - BIAS));
    return x[W-1] ? -v : v;
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    vectors++;
    chk("R9 out_valid", {3'b0, out_valid}, {3'b0, e_valid});
    chk("R5 of/sf/af", {1'b0, of, sf, af}, 4'b0);
    chk(e_tag, {1'b0, zf, pf, cf}, {1'b0, e_flags});
    if (e_valid) begin
      chk(ordered_mode ? "R7 invalid" : "R6 invalid", {3'b0, invalid}, {3'b0, e_inv});
      chk("R8 flag_we", {3'b0, flag_we}, {3'b0, e_we});
    end else begin
      chk("R9 idle", {2'b0, flag_we, invalid}, 4'b0);
    end
  endtask

  task automatic step(bit v, logic [W-1:0] a, logic [W-1:0] b, bit md, bit mk);
    bit un, rs;
    real ra, rb;
    @(negedge clk);
    check_outputs();
    un = is_nan(a) || is_nan(b);
    rs = md ? un : (is_snan(a) || is_snan(b));
    e_valid = v;
    e_inv = v && rs;
    e_we = v && !(rs && !mk);
    if (!v) e_tag = "R9 hold";
    else if (!e_we) e_tag = "R8 hold";
    else begin
      ra = value(a);
      rb = value(b);
      if (un) begin e_flags = 3'b111; e_tag = "R1 unordered"; end
      else if (ra == rb) begin e_flags = 3'b100; e_tag = "R4 equal"; end
      else if (ra < rb) begin e_flags = 3'b001; e_tag = "R3 less"; end
      else begin e_flags = 3'b000; e_tag = "R2 greater"; end
    end
    in_valid = v; op_a = a; op_b = b; ordered_mode = md; inv_mask = mk;
  endtask

  initial begin
    int n = 0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    e_tag = "R10 reset";
    check_outputs();
    rst = 1'b0;
    for (int cfg = 0; cfg < 4; cfg++) begin
      for (int a = 0; a < (1 << W); a++) begin
        for (int b = 0; b < (1 << W); b++) begin
          n++;
          if (n % 7 == 0) step(0, W'(b), W'(a), cfg[0], cfg[1]);
          step(1, W'(a), W'(b), cfg[0], cfg[1]);
        end
      end
    end
    step(0, '0, '0, 0, 0);
    step(0, '0, '0, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule